// File: doc/BRIEF.md
# Two-Tier Interrupt Selector with Delegation

This combinational block decides whether the hart must take an interrupt now, and which one. It receives the vector of interrupts that are both pending and individually enabled, the delegation mask, the current privilege level, and the two global enable bits for the machine and supervisor levels. It returns a take flag and a full-width cause word that trap entry can record as it is.

Selection happens in two tiers. The first tier holds the pending interrupts that are not delegated, and it qualifies when machine-level interrupts are enabled. The second tier holds the delegated pending interrupts, and it is looked at only when the first tier is empty and supervisor-level interrupts are enabled. Inside the chosen tier the lowest bit index wins.

The block also holds the write masks of the interrupt-enable and delegation registers. Given a register's current value and a write value, it returns the next value, in which only the implemented bits take the write. Trap entry, status stacking and vector addresses are handled elsewhere.

Top module: `irq_arbiter`

## Requirements
- R1: Privilege is encoded as user=0, supervisor=1, machine=3; level 2 counts as below machine and not below supervisor. The machine enable is true when the privilege is below machine, or when it is machine and `m_gie` is 1.
- R2: Pending bits whose delegation bit is 0 form the first tier, which qualifies only under the machine enable.
- R3: Pending bits whose delegation bit is 1 are considered only when the first tier is empty. They qualify only under the supervisor enable: privilege user, or supervisor with `s_gie` set.
- R4: Within the selected tier, the lowest-numbered set bit wins, even when a lower bit is pending but fails to qualify.
- R5: When an interrupt is taken, `take_irq` is 1, `irq_cause[XLEN-1]` is 1, the winning index sits in the low $clog2(XLEN) bits, and all other bits are 0.
- R6: When nothing qualifies, `take_irq` is 0 and `irq_cause` is all zero.
- R7: The delegation write mask covers only supervisor software (bit 1), supervisor timer (bit 5), supervisor external (bit 9) and the coprocessor line (bit COP_IRQ, default 12). `dg_next` takes these bits from `dg_wdata` and all other bits from `dg_cur`.
- R8: The enable write mask covers the R7 bits plus machine software (bit 3) and machine timer (bit 7). `ie_next` takes these bits from `ie_wdata` and all other bits from `ie_cur`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl | input | 2 | Current privilege level |
| m_gie | input | 1 | Global machine interrupt enable |
| s_gie | input | 1 | Global supervisor interrupt enable |
| irq_pend | input | XLEN | Pending-and-enabled interrupt vector |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| take_irq | output | 1 | An interrupt must be taken |
| irq_cause | output | XLEN | Cause word of the winner |
| ie_cur | input | XLEN | Current interrupt-enable register |
| ie_wdata | input | XLEN | Value written to the enable register |
| ie_next | output | XLEN | Masked next enable value |
| dg_cur | input | XLEN | Current delegation register |
| dg_wdata | input | XLEN | Value written to the delegation register |
| dg_next | output | XLEN | Masked next delegation value |

## Verification
Every privilege level, including the unused level 2, is crossed with all four settings of the two global enables. Each combination is applied to pending and delegation patterns that are all zero, entirely non-delegated, entirely delegated and mixed, and the result is compared with an independent model. This separates the machine and supervisor enable rules from one another and from the tier order. Directed vectors cover a delegated lowest bit beside a higher non-delegated bit, a blocked first tier that passes control to the second, and the top bit as winner. Write masks are checked with all-ones and all-zeros write data over opposite current values, which shows which bits take the write and which keep their value.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int XLEN    = 64,
  parameter int COP_IRQ = 12
) (
  input  logic [1:0]      priv_lvl,
  input  logic            m_gie,
  input  logic            s_gie,
  input  logic [XLEN-1:0] irq_pend,
  input  logic [XLEN-1:0] irq_deleg,
  output logic            take_irq,
  output logic [XLEN-1:0] irq_cause,
  input  logic [XLEN-1:0] ie_cur,
  input  logic [XLEN-1:0] ie_wdata,
  output logic [XLEN-1:0] ie_next,
  input  logic [XLEN-1:0] dg_cur,
  input  logic [XLEN-1:0] dg_wdata,
  output logic [XLEN-1:0] dg_next
);
  localparam int IW = $clog2(XLEN);
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] DG_MASK = (ONE << 1) | (ONE << 5) | (ONE << 9) | (ONE << COP_IRQ);
  localparam logic [XLEN-1:0] IE_MASK = DG_MASK | (ONE << 3) | (ONE << 7);

  logic            m_en, s_en;
  logic [XLEN-1:0] tier_m, tier_s, chosen;
  logic [IW-1:0]   win_idx;

  assign m_en   = (priv_lvl != PRIV_M) || m_gie;
  assign s_en   = (priv_lvl == PRIV_U) || ((priv_lvl == PRIV_S) && s_gie);
  assign tier_m = irq_pend & ~irq_deleg & {XLEN{m_en}};
  assign tier_s = irq_pend &  irq_deleg & {XLEN{s_en}};
  assign chosen = (|tier_m) ? tier_m : tier_s;

  always_comb begin
    win_idx = '0;
    for (int i = XLEN - 1; i >= 0; i--)
      if (chosen[i]) win_idx = IW'(i);
  end

  assign take_irq = |chosen;

  always_comb begin
    irq_cause = '0;
    if (take_irq) begin
      irq_cause[XLEN-1] = 1'b1;
      irq_cause[IW-1:0] = win_idx;
    end
  end

  assign ie_next = (ie_cur & ~IE_MASK) | (ie_wdata & IE_MASK);
  assign dg_next = (dg_cur & ~DG_MASK) | (dg_wdata & DG_MASK);

  always_comb begin
    AST_IDLE_ZERO: assert (take_irq || (irq_cause == '0)) else $error("idle cause nonzero"); // R6
    AST_CAUSE_TOP: assert (!take_irq || irq_cause[XLEN-1]) else $error("cause top bit clear"); // R5
    AST_WIN_PENDING: assert (!take_irq || irq_pend[irq_cause[IW-1:0]]) else $error("winner not pending"); // R4
    AST_TIER_ORDER: assert (!(take_irq && irq_deleg[irq_cause[IW-1:0]] && m_en && |(irq_pend & ~irq_deleg)))
      else $error("delegated winner over machine tier"); // R3
    AST_IE_KEEP: assert ((ie_next & ~IE_MASK) == (ie_cur & ~IE_MASK)) else $error("enable mask leak"); // R8
    AST_DG_KEEP: assert ((dg_next & ~DG_MASK) == (dg_cur & ~DG_MASK)) else $error("delegation mask leak"); // R7
  end
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int XLEN = 64;
  localparam int COP  = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]      priv_lvl;
  logic            m_gie, s_gie;
  logic [XLEN-1:0] irq_pend, irq_deleg, irq_cause;
  logic            take_irq;
  logic [XLEN-1:0] ie_cur, ie_wdata, ie_next, dg_cur, dg_wdata, dg_next;

  int n_chk = 0;
  int n_bad = 0;

  irq_arbiter uut (
    .priv_lvl(priv_lvl), .m_gie(m_gie), .s_gie(s_gie),
    .irq_pend(irq_pend), .irq_deleg(irq_deleg),
    .take_irq(take_irq), .irq_cause(irq_cause),
    .ie_cur(ie_cur), .ie_wdata(ie_wdata), .ie_next(ie_next),
    .dg_cur(dg_cur), .dg_wdata(dg_wdata), .dg_next(dg_next)
  );

  localparam logic [XLEN-1:0] DGM = (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 9) | (64'd1 << COP);
  localparam logic [XLEN-1:0] IEM = DGM | (64'd1 << 3) | (64'd1 << 7);

  function automatic logic [XLEN:0] model(input logic [1:0] p, input logic mg, input logic sg,
                                          input logic [XLEN-1:0] pend, input logic [XLEN-1:0] dg);
    logic me, se;
    logic [XLEN-1:0] set;
    me = (p < 2'd3) || mg;
    se = (p == 2'd0) || (p == 2'd1 && sg);
    set = me ? (pend & ~dg) : '0;
    if (set == '0) set = se ? (pend & dg) : '0;
    model = '0;
    for (int i = 0; i < XLEN; i++)
      if (set[i]) begin
        model[XLEN] = 1'b1;
        model[XLEN-1:0] = (64'd1 << 63) | 64'(i);
        return model;
      end
  endfunction

  task automatic cmp(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] p, input logic mg, input logic sg,
                       input logic [XLEN-1:0] pend, input logic [XLEN-1:0] dg);
    logic [XLEN:0] e;
    @(posedge clk);
    priv_lvl = p; m_gie = mg; s_gie = sg; irq_pend = pend; irq_deleg = dg;
    @(negedge clk);
    e = model(p, mg, sg, pend, dg);
    cmp({tag, " take"}, {63'd0, take_irq}, {63'd0, e[XLEN]});
    cmp({tag, " cause"}, irq_cause, e[XLEN-1:0]);
  endtask

  task automatic t_reset_state;
    @(posedge clk);
    priv_lvl = 2'd3; m_gie = 0; s_gie = 0; irq_pend = '0; irq_deleg = '0;
    ie_cur = '0; ie_wdata = '0; dg_cur = '0; dg_wdata = '0;
    @(negedge clk);
    cmp("R6 idle take", {63'd0, take_irq}, 64'd0);
    cmp("R6 idle cause", irq_cause, 64'd0);
    cmp("R8 idle ie", ie_next, 64'd0);
    cmp("R7 idle dg", dg_next, 64'd0);
  endtask

  task automatic t_sweep;
    logic [XLEN-1:0] pends [6] = '{64'h0, 64'h0000_0000_0000_02a2, 64'h0000_0000_0000_1222,
                                    64'h8000_0000_0000_0080, 64'h0000_0000_0000_0a88, 64'hffff_ffff_ffff_ffff};
    logic [XLEN-1:0] dgs [4] = '{64'h0, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_1222, 64'h0000_0000_0000_0200};
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 4; e++)
        for (int a = 0; a < 6; a++)
          for (int d = 0; d < 4; d++)
            apply("R1 R2 R3 sweep", 2'(p), e[1], e[0], pends[a], dgs[d]);
  endtask

  task automatic t_lowest_delegated;
    apply("R4 low delegated, M", 2'd3, 1'b1, 1'b1, 64'h0000_0000_0000_0082, 64'h2);
    cmp("R4 winner index 7", irq_cause, (64'd1 << 63) | 64'd7);
    apply("R3 machine tier blocked", 2'd3, 1'b0, 1'b1, 64'h0000_0000_0000_0082, 64'h2);
    cmp("R3 blocked result", {63'd0, take_irq}, 64'd0);
    apply("R3 supervisor fallback", 2'd1, 1'b0, 1'b1, 64'h0000_0000_0000_0022, 64'h22);
    cmp("R3 fallback cause", irq_cause, (64'd1 << 63) | 64'd1);
    apply("R3 supervisor sie off", 2'd1, 1'b1, 1'b0, 64'h0000_0000_0000_0020, 64'h20);
    cmp("R3 sie off result", {63'd0, take_irq}, 64'd0);
    apply("R1 user ignores mie", 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0008, 64'h0);
    cmp("R1 user cause", irq_cause, (64'd1 << 63) | 64'd3);
    apply("R5 top bit winner", 2'd3, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h0);
    cmp("R5 top cause", irq_cause, (64'd1 << 63) | 64'd63);
  endtask

  task automatic t_masks;
    @(posedge clk);
    ie_cur = '0; ie_wdata = '1; dg_cur = '0; dg_wdata = '1;
    @(negedge clk);
    cmp("R8 ie set", ie_next, IEM);
    cmp("R7 dg set", dg_next, DGM);
    @(posedge clk);
    ie_cur = '1; ie_wdata = '0; dg_cur = '1; dg_wdata = '0;
    @(negedge clk);
    cmp("R8 ie clear", ie_next, ~IEM);
    cmp("R7 dg clear", dg_next, ~DGM);
    @(posedge clk);
    ie_cur = 64'h5555_0000_0000_0000; ie_wdata = 64'h0000_0000_0000_1088;
    dg_cur = 64'h0; dg_wdata = 64'h0000_0000_0000_008a;
    @(negedge clk);
    cmp("R8 ie mixed", ie_next, 64'h5555_0000_0000_1088);
    cmp("R7 dg drops bits 3 7", dg_next, 64'h2);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_sweep();
    t_lowest_delegated();
    t_masks();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule